// File: doc/BRIEF.md
# Descriptor Table Selector Validator

This block vets a 16-bit selector before it is allowed into a segment register, the local-table register or the task register. It keeps a base and a limit for two descriptor tables: a global table that every task shares and a local table that belongs to the running task. Loading a new local table register on a task switch replaces the local table's base and limit. For each request the block picks the table named by the selector, works out where the 8-byte descriptor lies, and checks that the whole descriptor fits under the table limit. The limit is the address of the last valid byte, so a table of N descriptors has a limit of 8·N − 1.

If the table and limit checks pass, the block presents the descriptor address and asks the memory side for the descriptor's access byte. An access byte of zero marks an unused slot and the load faults. Any other value accepts the load. Each fault comes with an error code built from the offending selector. Type and privilege checks on the descriptor belong to other logic. The block only decides whether the slot exists and is occupied.

The controller is a five-state machine. IDLE takes a request (transition *start*) into CHECK. CHECK goes to FAULT on a bad table choice or a limit miss (*reject*), and otherwise goes to FETCH (*lookup*). FETCH holds until the access byte arrives, then goes to ACCEPT (*occupied*) or FAULT (*empty*). ACCEPT and FAULT each last one cycle and then return to IDLE (*done*).

Top module: `seg_sel_validator`

## Requirements
- R1: After reset the machine is idle: `busy`, `accept`, `fault` and `rd_req` are low. Both tables have base 0 and limit 0, so every selector fails the limit check.
- R2: A pulse on `gt_wr` loads the global base and limit. A pulse on `lt_wr` (task switch) replaces the local base and limit. Later checks use the new values.
- R3: Selector fields are: bits 15:3 the index, bit 2 the table select (1 = local, 0 = global), bits 1:0 the requested privilege. Bits 1:0 have no effect on the address or on the outcome.
- R4: The descriptor address on `desc_addr` is the selected table's base + index·8, kept to its low 24 bits (it wraps past 0xFFFFFF).
- R5: The limit check passes only when index·8 + 7 ≤ the selected table's limit. A miss faults with no access-byte fetch.
- R6: `req_kind` encodes the target: 2'b00 segment register, 2'b01 local-table register, 2'b10 task register, 2'b11 treated like 2'b10. Any code other than 2'b00 with selector bit 2 set faults with no fetch.
- R7: An access byte of 8'h00 makes the request fault. Any non-zero access byte makes it accept.
- R8: `accept` and `fault` are single-cycle pulses and never high together. While `fault` is high, `err_code` equals the selector with bits 1:0 cleared.
- R9: A request is taken only in IDLE. `req_valid` while `busy` is high is ignored and does not start a second check.
- R10: Table and limit faults, and the rise of `rd_req`, come on the second clock edge after the request is taken. The `accept` or `fault` that follows an access byte comes on the edge that samples `ab_valid`.
- R11: `rd_req` stays high with `desc_addr` unchanged until `ab_valid` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gt_wr | input | 1 | Load global table base/limit |
| gt_base | input | 24 | Global table base |
| gt_lim | input | 16 | Global table limit (last valid byte) |
| lt_wr | input | 1 | Load local table base/limit (task switch) |
| lt_base | input | 24 | Local table base |
| lt_lim | input | 16 | Local table limit (last valid byte) |
| req_valid | input | 1 | Selector check request |
| req_sel | input | 16 | Selector to check |
| req_kind | input | 2 | Load target code |
| ab_valid | input | 1 | Access byte present |
| ab_data | input | 8 | Fetched access byte |
| rd_req | output | 1 | Access byte fetch request |
| desc_addr | output | 24 | Descriptor address |
| accept | output | 1 | Selector accepted (pulse) |
| fault | output | 1 | Selector rejected (pulse) |
| err_code | output | 16 | Selector with privilege bits cleared |
| busy | output | 1 | Check in progress |

## Verification
The request is driven at a falling edge and taken on the next rising edge. The bench samples at the falling edge one cycle later to confirm `busy`. It samples again at the falling edge after the second rising edge, where either a table/limit fault or a raised `rd_req` with its address must be visible. Once `ab_valid` is driven for one edge, the following falling edge must show exactly one of `accept` and `fault`. One cycle after that, everything must be quiet again. The bench varies how long `rd_req` waits before the access byte arrives, and checks the address at every one of those cycles, so the result never depends on a fixed fetch latency.

// File: rtl/sv_sel_pkg.sv
package sv_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_ACCEPT,
        ST_FAULT
    } vstate_t;

    typedef enum logic [1:0] {
        LD_SEG = 2'b00,
        LD_LTR = 2'b01,
        LD_TSK = 2'b10,
        LD_RSV = 2'b11
    } load_kind_t;

    localparam int NUM_TABLES = 2;
    localparam int TBL_GLOBAL = 0;
    localparam int TBL_LOCAL  = 1;

endpackage

// File: rtl/sv_table_regs.sv
module sv_table_regs #(
    parameter int AW = 24,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          g_wr,
    input  logic [AW-1:0] g_base,
    input  logic [LW-1:0] g_lim,
    input  logic          l_wr,
    input  logic [AW-1:0] l_base,
    input  logic [LW-1:0] l_lim,
    input  logic          use_local,
    output logic [AW-1:0] sel_base,
    output logic [LW-1:0] sel_lim
);
    import sv_sel_pkg::*;

    logic [AW-1:0] base_r [NUM_TABLES];
    logic [LW-1:0] lim_r  [NUM_TABLES];
    logic          wr_v   [NUM_TABLES];
    logic [AW-1:0] base_v [NUM_TABLES];
    logic [LW-1:0] lim_v  [NUM_TABLES];

    assign wr_v[TBL_GLOBAL]   = g_wr;
    assign base_v[TBL_GLOBAL] = g_base;
    assign lim_v[TBL_GLOBAL]  = g_lim;
    assign wr_v[TBL_LOCAL]    = l_wr;
    assign base_v[TBL_LOCAL]  = l_base;
    assign lim_v[TBL_LOCAL]   = l_lim;

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_r[t] <= '0;
                lim_r[t]  <= '0;
            end else if (wr_v[t]) begin
                base_r[t] <= base_v[t];
                lim_r[t]  <= lim_v[t];
            end
        end
    end

    assign sel_base = use_local ? base_r[TBL_LOCAL] : base_r[TBL_GLOBAL];
    assign sel_lim  = use_local ? lim_r[TBL_LOCAL]  : lim_r[TBL_GLOBAL];

endmodule

// File: rtl/sv_addr_unit.sv
module sv_addr_unit #(
    parameter int AW = 24,
    parameter int LW = 16,
    parameter int SW = 16
) (
    input  logic [SW-1:0] sel,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] lim,
    output logic [AW-1:0] addr,
    output logic          limit_ok,
    output logic          table_ok
);
    localparam int TI_BIT = 2;
    localparam int IX_LSB = 3;
    localparam int CW     = (SW > LW) ? SW : LW;

    logic [SW-1:0] offs;
    logic [CW-1:0] last_byte;
    logic [CW-1:0] lim_ext;

    assign offs      = {sel[SW-1:IX_LSB], {IX_LSB{1'b0}}};
    assign last_byte = CW'({sel[SW-1:IX_LSB], {IX_LSB{1'b1}}});
    assign lim_ext   = CW'(lim);
    assign limit_ok  = (last_byte <= lim_ext);
    assign table_ok  = (kind == 2'b00) || !sel[TI_BIT];
    assign addr      = base + AW'(offs);

endmodule

// File: rtl/seg_sel_validator.sv
module seg_sel_validator #(
    parameter int AW = 24,
    parameter int LW = 16,
    parameter int SW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gt_wr,
    input  logic [AW-1:0] gt_base,
    input  logic [LW-1:0] gt_lim,
    input  logic          lt_wr,
    input  logic [AW-1:0] lt_base,
    input  logic [LW-1:0] lt_lim,
    input  logic          req_valid,
    input  logic [SW-1:0] req_sel,
    input  logic [1:0]    req_kind,
    input  logic          ab_valid,
    input  logic [BW-1:0] ab_data,
    output logic          rd_req,
    output logic [AW-1:0] desc_addr,
    output logic          accept,
    output logic          fault,
    output logic [SW-1:0] err_code,
    output logic          busy
);
    import sv_sel_pkg::*;

    localparam int TI_BIT = 2;
    localparam int RPL_W  = 2;

    vstate_t       state, nxt;
    logic [SW-1:0] sel_q;
    logic [1:0]    kind_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] tb_base;
    logic [LW-1:0] tb_lim;
    logic [AW-1:0] calc_addr;
    logic          lim_ok, tbl_ok;

    sv_table_regs #(.AW(AW), .LW(LW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .g_wr(gt_wr), .g_base(gt_base), .g_lim(gt_lim),
        .l_wr(lt_wr), .l_base(lt_base), .l_lim(lt_lim),
        .use_local(sel_q[TI_BIT]),
        .sel_base(tb_base), .sel_lim(tb_lim)
    );

    sv_addr_unit #(.AW(AW), .LW(LW), .SW(SW)) u_addr (
        .sel(sel_q), .kind(kind_q), .base(tb_base), .lim(tb_lim),
        .addr(calc_addr), .limit_ok(lim_ok), .table_ok(tbl_ok)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_CHECK;
            ST_CHECK:  nxt = (tbl_ok && lim_ok) ? ST_FETCH : ST_FAULT;
            ST_FETCH:  if (ab_valid) nxt = (ab_data == '0) ? ST_FAULT : ST_ACCEPT;
            ST_ACCEPT: nxt = ST_IDLE;
            ST_FAULT:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sel_q  <= '0;
            kind_q <= '0;
            addr_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_valid) begin
                sel_q  <= req_sel;
                kind_q <= req_kind;
            end
            if (state == ST_CHECK) addr_q <= calc_addr;
        end
    end

    // outputs
    always_comb begin
        rd_req    = 1'b0;
        accept    = 1'b0;
        fault     = 1'b0;
        busy      = 1'b1;
        desc_addr = addr_q;
        err_code  = {sel_q[SW-1:RPL_W], {RPL_W{1'b0}}};
        unique case (state)
            ST_IDLE:   busy   = 1'b0;
            ST_CHECK:  ;
            ST_FETCH:  rd_req = 1'b1;
            ST_ACCEPT: accept = 1'b1;
            ST_FAULT:  fault  = 1'b1;
            default:   busy   = 1'b0;
        endcase
    end

endmodule

// File: rtl/sv_sel_checker.sv
module sv_sel_checker #(
    parameter int AW = 24,
    parameter int SW = 16,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          ab_valid,
    input logic [BW-1:0] ab_data,
    input logic          rd_req,
    input logic [AW-1:0] desc_addr,
    input logic          accept,
    input logic          fault,
    input logic [SW-1:0] err_code,
    input logic          busy
);
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, fault, rd_req}));

    assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    assert_accept_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    assert_err_rpl_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (err_code[1:0] == 2'b00));

    assert_empty_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ab_valid && ab_data == '0) |=> fault);

    assert_used_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ab_valid && ab_data != '0) |=> accept);

    assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ab_valid) |=> (rd_req && $stable(desc_addr)));

    assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && !accept && !fault && !rd_req));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || fault) |=> !busy);

endmodule

bind seg_sel_validator sv_sel_checker #(.AW(AW), .SW(SW), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .ab_valid(ab_valid), .ab_data(ab_data), .rd_req(rd_req),
    .desc_addr(desc_addr), .accept(accept), .fault(fault),
    .err_code(err_code), .busy(busy)
);

// File: tb/sim_seg_sel_validator.sv
`timescale 1ns/1ps
module sim_seg_sel_validator;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gt_wr, lt_wr, req_valid, ab_valid;
    logic [23:0] gt_base, lt_base;
    logic [15:0] gt_lim, lt_lim, req_sel;
    logic [1:0]  req_kind;
    logic [7:0]  ab_data;
    logic        rd_req, accept, fault, busy;
    logic [23:0] desc_addr;
    logic [15:0] err_code;

    int errors = 0;
    int checks = 0;
    logic [23:0] m_gbase = '0, m_lbase = '0;
    logic [15:0] m_glim = '0, m_llim = '0;

    always #2.5 clk = ~clk;

    seg_sel_validator u0 (
        .clk(clk), .rst_n(rst_n),
        .gt_wr(gt_wr), .gt_base(gt_base), .gt_lim(gt_lim),
        .lt_wr(lt_wr), .lt_base(lt_base), .lt_lim(lt_lim),
        .req_valid(req_valid), .req_sel(req_sel), .req_kind(req_kind),
        .ab_valid(ab_valid), .ab_data(ab_data),
        .rd_req(rd_req), .desc_addr(desc_addr), .accept(accept),
        .fault(fault), .err_code(err_code), .busy(busy)
    );

    task automatic chk(string rq, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_addr(logic [15:0] s);
        logic [23:0] b;
        b = s[2] ? m_lbase : m_gbase;
        return b + {8'h00, s[15:3], 3'b000};
    endfunction

    function automatic bit exp_early_fault(logic [15:0] s, logic [1:0] k);
        logic [16:0] last;
        logic [15:0] l;
        l = s[2] ? m_llim : m_glim;
        last = {1'b0, s[15:3], 3'b111};
        return (k != 2'b00 && s[2]) || (last > {1'b0, l});
    endfunction

    task automatic load_g(logic [23:0] b, logic [15:0] l);
        @(negedge clk); gt_wr = 1'b1; gt_base = b; gt_lim = l;
        @(negedge clk); gt_wr = 1'b0;
        m_gbase = b; m_glim = l;
    endtask

    task automatic load_l(logic [23:0] b, logic [15:0] l);
        @(negedge clk); lt_wr = 1'b1; lt_base = b; lt_lim = l;
        @(negedge clk); lt_wr = 1'b0;
        m_lbase = b; m_llim = l;
    endtask

    // one request; returns whether it ended in fault
    task automatic run_req(logic [15:0] s, logic [1:0] k, logic [7:0] ab,
                           int wait_n, bit inject, output bit faulted,
                           output logic [23:0] got_addr);
        bit early;
        early = exp_early_fault(s, k);
        got_addr = '0;
        @(negedge clk); req_valid = 1'b1; req_sel = s; req_kind = k;
        @(negedge clk);
        chk("R9", "busy after start", busy, 1);
        chk("R10", "no early outcome", {accept, fault, rd_req}, 0);
        if (inject) req_sel = s ^ 16'hFFF8; else req_valid = 1'b0;
        @(negedge clk); req_valid = 1'b0;
        if (early) begin
            chk("R5", "early fault", fault, 1);
            chk("R6", "no fetch on reject", rd_req, 0);
            chk("R8", "err code", err_code, {s[15:2], 2'b00});
            faulted = 1'b1;
        end else begin
            chk("R10", "fetch raised", rd_req, 1);
            chk("R4", "descriptor address", desc_addr, exp_addr(s));
            got_addr = desc_addr;
            for (int i = 0; i < wait_n; i++) begin
                @(negedge clk);
                chk("R11", "fetch held", rd_req, 1);
                chk("R11", "address stable", desc_addr, exp_addr(s));
            end
            ab_valid = 1'b1; ab_data = ab;
            @(negedge clk); ab_valid = 1'b0;
            chk("R7", "accept", accept, ab != 8'h00);
            chk("R7", "fault", fault, ab == 8'h00);
            if (ab == 8'h00) chk("R8", "err code", err_code, {s[15:2], 2'b00});
            faulted = (ab == 8'h00);
        end
        @(negedge clk);
        chk("R8", "pulse ends", {accept, fault}, 0);
        chk("R9", "back to idle", busy, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit f;
        logic [23:0] a0, a1;
        void'($urandom(32'd4242));
        rst_n = 1'b0; gt_wr = 0; lt_wr = 0; req_valid = 0; ab_valid = 0;
        gt_base = '0; lt_base = '0; gt_lim = '0; lt_lim = '0;
        req_sel = '0; req_kind = '0; ab_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle outputs", {busy, accept, fault, rd_req}, 0);
        run_req(16'h0000, 2'b00, 8'h92, 0, 0, f, a0);
        chk("R1", "zero limit rejects", f, 1);

        // R2: global table of 4 entries
        load_g(24'h100000, 16'd31);
        run_req({13'd3, 3'b000}, 2'b00, 8'h92, 1, 0, f, a0);
        chk("R5", "last entry fits", f, 0);
        run_req({13'd4, 3'b000}, 2'b00, 8'h92, 0, 0, f, a0);
        chk("R5", "one past limit", f, 1);
        // R3: privilege bits do not move the address
        run_req({13'd2, 3'b011}, 2'b00, 8'h81, 0, 0, f, a1);
        run_req({13'd2, 3'b000}, 2'b00, 8'h81, 0, 0, f, a0);
        chk("R3", "rpl ignored", a1, a0);
        // R4: local wrap past 24 bits
        load_l(24'hFFFFF8, 16'd15);
        run_req({13'd1, 3'b100}, 2'b00, 8'h92, 0, 0, f, a0);
        chk("R4", "wrapped address", a0, 24'h000000);
        // R6: local-table and task register loads must use global
        run_req({13'd0, 3'b100}, 2'b01, 8'h82, 0, 0, f, a0);
        chk("R6", "ldtr from local", f, 1);
        run_req({13'd1, 3'b100}, 2'b10, 8'h89, 0, 0, f, a0);
        chk("R6", "task reg from local", f, 1);
        run_req({13'd1, 3'b000}, 2'b10, 8'h89, 0, 0, f, a0);
        chk("R6", "task reg from global", f, 0);
        // R2: task switch replaces local table
        load_l(24'h004000, 16'd7);
        run_req({13'd1, 3'b100}, 2'b00, 8'h92, 0, 0, f, a0);
        chk("R2", "new local limit", f, 1);
        run_req({13'd0, 3'b100}, 2'b00, 8'h92, 0, 0, f, a0);
        chk("R2", "new local base", a0, 24'h004000);
        // R7: empty slot; R9: request during busy ignored
        run_req({13'd1, 3'b000}, 2'b00, 8'h00, 2, 1, f, a0);
        chk("R7", "empty slot faults", f, 1);

        for (int n = 0; n < 300; n++) begin
            logic [15:0] s;
            logic [7:0]  ab;
            if ($urandom % 10 == 0) begin
                if ($urandom % 2 == 0)
                    load_g($urandom, ($urandom % 4 == 0) ? 16'($urandom % 512)
                                                         : 16'((($urandom % 64) + 1) * 8 - 1));
                else
                    load_l($urandom, ($urandom % 4 == 0) ? 16'($urandom % 512)
                                                         : 16'((($urandom % 64) + 1) * 8 - 1));
            end
            s = {13'($urandom % 80), 3'($urandom)};
            if ($urandom % 8 == 0) s = 16'($urandom);
            ab = ($urandom % 4 == 0) ? 8'h00 : (8'($urandom) | 8'h01);
            run_req(s, 2'($urandom), ab, $urandom % 3, 1'($urandom), f, a0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule